// File: doc/BRIEF.md
# Region-Decoded Word Memory

This block is a word-addressed store for a small 16-bit processor. Every address, write word and read word is 16 bits wide. The address space has three parts. The lowest 256 words hold a fixed program image. The next part, up to word 0x3FFF, is writable storage. Everything from 0x4000 upward is unpopulated.

A read is combinational: the read port follows the address without waiting for a clock. A write takes effect at the rising clock edge while the write enable is high. A write only changes storage when the address falls in the writable region. Writes that land in the fixed image or in the unpopulated space are dropped and change nothing. Reads of unpopulated addresses return zero.

The fixed image is computed rather than stored. For an address whose low byte is `b`, the word is `{b ^ 8'h5A, ~b}`, with the upper byte first.

Top module: `region_mem`

## Requirements
- R1: A read at any address from 0x0000 to 0x00FF returns the fixed image word: upper byte = (low address byte XOR 0x5A), lower byte = bitwise NOT of the low address byte.
- R2: A write with enable high to an address from 0x0000 to 0x00FF does not alter the word later read from that address.
- R3: A write with enable high to an address from 0x0100 to 0x3FFF stores the write word at the rising edge. Later reads of that address return it until it is overwritten.
- R4: The read word follows an address change within the same clock period, with no clock edge in between.
- R5: A read at any address from 0x4000 to 0xFFFF returns 0x0000.
- R6: A write with enable high to an address from 0x4000 to 0xFFFF has no effect. The read there stays 0x0000, and no writable word changes, including the word whose low 14 address bits match.
- R7: The region edges decode exactly: 0x00FF is fixed image, 0x0100 and 0x3FFF are writable, and 0x4000 is unpopulated.
- R8: While the enable is low, a clock edge leaves every writable word unchanged, whatever the address and write word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect at the rising edge |
| addr | input | 16 | Word address |
| wdata | input | 16 | Word to store |
| wr_en | input | 1 | Write enable, active high |
| rdata | output | 16 | Word read at addr (combinational) |

## Verification
The bench goes after the four decode edges. If a comparison were off by one, 0x00FF or 0x3FFF would fall into the wrong region, or 0x0100 would be refused as a write target. It writes to the unpopulated space at an address whose low bits alias a stored writable word. A decoder that ignored the top address bits would then overwrite that word. It also writes to the fixed image and then reads it back, which catches a write path that was never gated. It moves the address with no clock edge in between, so a read path registered by mistake returns a stale word.

// File: rtl/region_mem_pkg.sv
package region_mem_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    REG_IMAGE = 2'd0,
    REG_STORE = 2'd1,
    REG_EMPTY = 2'd2
  } region_e;

  // Region of a word address for a given map split.
  function automatic region_e region_of(input logic [ADDR_W-1:0] a,
                                        input int image_words,
                                        input int store_top);
    if (int'(a) < image_words)      return REG_IMAGE;
    else if (int'(a) <= store_top)  return REG_STORE;
    else                            return REG_EMPTY;
  endfunction

  // Fixed image pattern: upper byte is low byte xor 0x5A, lower byte its inverse.
  function automatic logic [DATA_W-1:0] image_word(input logic [ADDR_W-1:0] a);
    logic [7:0] b;
    b = a[7:0];
    return {b ^ 8'h5A, ~b};
  endfunction
endpackage

// File: rtl/region_decode.sv
module region_decode
  import region_mem_pkg::*;
#(
  parameter int IMAGE_WORDS = 256,
  parameter int STORE_TOP   = 16'h3FFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_image,
  output logic              sel_store,
  output logic              sel_empty
);
  region_e reg_now;

  always_comb begin
    reg_now   = region_of(addr, IMAGE_WORDS, STORE_TOP);
    sel_image = (reg_now == REG_IMAGE);
    sel_store = (reg_now == REG_STORE);
    sel_empty = (reg_now == REG_EMPTY);
  end

  // R7
  always_comb begin
    one_region_chk: assert ($countones({sel_image, sel_store, sel_empty}) == 1)
      else $error("address decoded into %0d regions", $countones({sel_image, sel_store, sel_empty}));
  end
endmodule

// File: rtl/image_table.sv
module image_table
  import region_mem_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word
);
  always_comb word = image_word(addr);
endmodule

// File: rtl/store_array.sv
module store_array
  import region_mem_pkg::*;
#(
  parameter int IMAGE_WORDS = 256,
  parameter int STORE_TOP   = 16'h3FFF
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword
);
  localparam int DEPTH = STORE_TOP - IMAGE_WORDS + 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  idx;
  logic              idx_ok;

  always_comb begin
    offset = addr - ADDR_W'(IMAGE_WORDS);
    idx    = IDX_W'(offset);
    idx_ok = (int'(offset) < DEPTH);
    rword  = idx_ok ? mem[idx] : '0;
  end

  always_ff @(posedge clk) begin
    if (we && idx_ok) mem[idx] <= wdata;
  end
endmodule

// File: rtl/region_mem.sv
module region_mem
  import region_mem_pkg::*;
#(
  parameter int IMAGE_WORDS = 256,
  parameter int STORE_TOP   = 16'h3FFF
) (
  input  logic              clk,
  input  logic [15:0]       addr,
  input  logic [15:0]       wdata,
  input  logic              wr_en,
  output logic [15:0]       rdata
);
  logic              sel_image, sel_store, sel_empty;
  logic              store_we;
  logic [DATA_W-1:0] image_rd, store_rd;

  region_decode #(.IMAGE_WORDS(IMAGE_WORDS), .STORE_TOP(STORE_TOP)) u_dec (
    .addr(addr), .sel_image(sel_image), .sel_store(sel_store), .sel_empty(sel_empty)
  );

  image_table u_img (.addr(addr), .word(image_rd));

  // Only the writable region ever sees the enable.
  assign store_we = wr_en & sel_store;

  store_array #(.IMAGE_WORDS(IMAGE_WORDS), .STORE_TOP(STORE_TOP)) u_store (
    .clk(clk), .we(store_we), .addr(addr), .wdata(wdata), .rword(store_rd)
  );

  always_comb begin
    unique case (1'b1)
      sel_image: rdata = image_rd;
      sel_store: rdata = store_rd;
      default:   rdata = '0;
    endcase
  end

  // Becomes 1 after the first edge, so clocked checks skip power-up values.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R5
  always_comb begin
    if (sel_empty) empty_zero_chk: assert (rdata == '0)
      else $error("unpopulated read gave %h", rdata);
  end

  // R3
  store_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    store_we |=> ($stable(addr) -> rdata == $past(wdata)));

  // R2
  image_no_write_chk: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && sel_image) |=> ($stable(addr) -> $stable(rdata)));

  // R6
  empty_no_write_chk: assert property (@(posedge clk) disable iff (!armed)
    (wr_en && sel_empty) |=> ($stable(addr) -> rdata == '0));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!armed)
    (!wr_en) |=> ($stable(addr) -> $stable(rdata)));
endmodule

// File: tb/region_mem_test.sv
module region_mem_test;
  logic        clk = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic        wr_en = 1'b0;
  logic [15:0] rdata;
  int checks = 0, errors = 0;
  bit done = 0;
  int model [int];   // written writable words only

  region_mem uut (.clk(clk), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata));

  always #5 clk = ~clk;

  function automatic int expect_of(int a, output bit known);
    known = 1;
    if (a < 256) return (((a % 256) ^ 90) * 256) + (255 - (a % 256));
    if (a >= 16384) return 0;
    if (model.exists(a)) return model[a];
    known = 0;
    return 0;
  endfunction

  task automatic check_now(string req);
    bit known;
    int e;
    e = expect_of(int'(addr), known);
    if (known) begin
      checks++;
      if (int'(rdata) != e) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, rdata, e[15:0]);
      end
    end
  endtask

  // Drive at the falling edge, compare combinational read, then apply the edge to the model.
  task automatic step(input logic [15:0] a, input logic [15:0] d, input logic we, input string req);
    @(negedge clk);
    addr = a; wdata = d; wr_en = we;
    #1 check_now(req);
    @(posedge clk);
    if (we && int'(a) >= 256 && int'(a) < 16384) model[int'(a)] = int'(d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 / R7: image reads, including the last image word
    step(16'h0000, 16'h0, 0, "R1");
    step(16'h0012, 16'h0, 0, "R1");
    step(16'h00FF, 16'h0, 0, "R7");
    // R3 / R7: writable region, including both edges
    step(16'h0100, 16'h1111, 1, "R3");
    step(16'h3FFF, 16'hBEEF, 1, "R3");
    step(16'h2345, 16'hA5A5, 1, "R3");
    step(16'h0100, 16'h0, 0, "R7");
    step(16'h3FFF, 16'h0, 0, "R7");
    step(16'h2345, 16'h0, 0, "R3");
    // R2: write into image is dropped
    step(16'h0010, 16'hFFFF, 1, "R2");
    step(16'h0010, 16'h0, 0, "R2");
    step(16'h00FF, 16'h1234, 1, "R2");
    step(16'h00FF, 16'h0, 0, "R2");
    // R5 / R6 / R7: unpopulated space, aliasing write
    step(16'h4000, 16'h0, 0, "R7");
    step(16'hFFFF, 16'h0, 0, "R5");
    step(16'h4100, 16'h7777, 1, "R6");
    step(16'h4100, 16'h0, 0, "R6");
    step(16'h0100, 16'h0, 0, "R6");
    step(16'h6345, 16'h5555, 1, "R6");
    step(16'h2345, 16'h0, 0, "R6");
    // R8: disabled write leaves storage alone
    step(16'h2345, 16'h0000, 0, "R8");
    step(16'h2345, 16'h0000, 0, "R8");
    step(16'h3FFF, 16'h0, 0, "R8");
    // R4: address moves with no edge in between
    @(negedge clk);
    addr = 16'h2345; wr_en = 0;
    #1 check_now("R4");
    addr = 16'h0100;
    #1 check_now("R4");
    addr = 16'h0042;
    #1 check_now("R4");
    addr = 16'h8000;
    #1 check_now("R4");
    // R3: sweep of writes then reads, with overwrite
    for (int i = 0; i < 24; i++) step(16'(16'h0180 + i * 517), 16'(i * 16'h0931 + 16'h0101), 1, "R3");
    for (int i = 0; i < 24; i++) step(16'(16'h0180 + i * 517), 16'h0, 0, "R3");
    step(16'h0180, 16'hCAFE, 1, "R3");
    step(16'h0180, 16'h0, 0, "R3");
    // R1: sweep of image
    for (int i = 0; i < 256; i += 37) step(16'(i), 16'hFFFF, 1, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule